// File: doc/BRIEF.md
# Step-Indexed Pattern Pin Channel Array

This block is the digital core of a pattern tester's I/O channels. A set of `NCH` channels shares one step address. Each channel keeps three per-step bit memories of its own: the pattern bit to drive, a direction bit, and a capture bit. While a run is active, a step strobe (`step_tick`) moves the sequencer through the steps one at a time. For every step, the direction bit decides whether the channel enables its pin driver and presents the stored pattern bit, or leaves the driver off so that the pin floats.

The sequencer also records the pin receiver into the capture memory on every step. This includes steps where the channel itself drives the pin, so the device's inputs and the tester's own drive are both recorded. A host port loads the pattern and direction memories and reads back captured words. It works only while the sequencer is stopped.

The sequencer has two named states. `SQ_IDLE` is the state after reset and after a run ends. `SQ_RUN` is active stepping. There are three transitions:
- **launch**: `SQ_IDLE` to `SQ_RUN`, on `run_start`.
- **finish**: `SQ_RUN` to `SQ_IDLE`, on a tick at the latched last step.
- **abort**: `SQ_RUN` to `SQ_IDLE`, on `run_stop`.

Top module: `pat_pin_array`

## Requirements
- R1: After reset the block is in `SQ_IDLE`. `running`, `step_addr`, `drv_en`, `drv_data` and every capture bit are 0.
- R2: A launch sets `step_addr` to 0, enters `SQ_RUN` on the next clock edge, and latches `last_step` (clamped to DEPTH-1). While running, `run_start` and later changes of `last_step` have no effect.
- R3: In `SQ_RUN`, each clock edge with `step_tick` high and `run_stop` low does one of two things:
  - If `step_addr` is below the latched last step, it increments `step_addr` by one.
  - If `step_addr` equals the latched last step, it ends the run (finish) and `step_addr` holds that value.
  - Edges without a tick leave `step_addr` unchanged.
- R4: While running, `drv_en[c]` equals the direction bit of channel c at the current step, where 1 means output and 0 means input. While idle, `drv_en` is all zero.
- R5: `drv_data[c]` equals the stored pattern bit of channel c at the current step when `drv_en[c]` is 1, and is 0 otherwise.
- R6: On each counted tick (R3), the capture bit of every channel at the current step takes the value on `pin_rx`. This applies to output steps as well as input steps. Steps that are not ticked keep their old capture bits.
- R7: `run_stop` while running ends the run at the next edge and takes priority over a tick in the same cycle. No capture happens on that edge.
- R8: A host write (`host_we`=1) sets the entry at `host_addr` to `host_wdata`. `host_sel`=0 selects the pattern memory and `host_sel`=1 selects the direction memory. The write takes effect only while idle; a write while running changes nothing.
- R9: While idle, `host_rdata` shows the captured word at `host_addr` combinationally. While running it reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_start | input | 1 | Launch a run from step 0 |
| run_stop | input | 1 | Abort the current run |
| step_tick | input | 1 | Out-clock step strobe |
| last_step | input | AW | Final step index, latched at launch |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 = pattern memory, 1 = direction memory |
| host_addr | input | AW | Host step address |
| host_wdata | input | NCH | Host write word, one bit per channel |
| host_rdata | output | NCH | Captured word at `host_addr` |
| pin_rx | input | NCH | Pin receiver values |
| drv_data | output | NCH | Driver data per channel |
| drv_en | output | NCH | Driver enable per channel (1 = drive) |
| running | output | 1 | High in `SQ_RUN` |
| step_addr | output | AW | Current step index |

## Verification
The pin is looped back as `drv_en ? drv_data : ext`, with a fresh random `ext` word on every step. A captured bit therefore shows the driven value on output steps and the outside value on input steps. A wrong direction gate, or a capture taken from the wrong source, makes the capture disagree with the bench's per-step prediction.

Three kinds of pattern are applied:
- Directed direction words: all-output and all-input steps.
- Random mixed direction words.
- Runs of full length, a single step and random length, with idle gaps between ticks. These separate a wrong step count or end condition from a stuck address.

Host writes and launch requests issued mid-run must leave the following run and the address unchanged. A tick paired with a stop must leave that step's capture untouched.

// File: rtl/pin_pkg.sv
package pin_pkg;
    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } sq_state_t;
endpackage

// File: rtl/step_seq.sv
module step_seq
    import pin_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          tick_i,
    input  logic [AW-1:0] last_i,
    output logic          run_o,
    output logic          cap_en_o,
    output logic [AW-1:0] addr_o
);
    localparam logic [AW-1:0] LAST_MAX = AW'(DEPTH - 1);

    sq_state_t     state_q, state_d;
    logic [AW-1:0] addr_q, addr_d;
    logic [AW-1:0] last_q, last_d;
    logic          at_last;
    logic          adv;

    assign at_last = (addr_q == last_q);
    assign adv     = (state_q == SQ_RUN) && tick_i && !stop_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            addr_q  <= '0;
            last_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            last_q  <= last_d;
        end
    end

    // next state: launch, finish, abort
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        last_d  = last_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (start_i) begin
                    state_d = SQ_RUN;
                    addr_d  = '0;
                    last_d  = (last_i > LAST_MAX) ? LAST_MAX : last_i;
                end
            end
            SQ_RUN: begin
                if (stop_i) begin
                    state_d = SQ_IDLE;
                end else if (tick_i) begin
                    if (at_last) state_d = SQ_IDLE;
                    else         addr_d  = addr_q + 1'b1;
                end
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        run_o    = (state_q == SQ_RUN);
        cap_en_o = adv;
        addr_o   = addr_q;
    end

    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_IDLE && start_i) |=> (run_o && addr_o == '0));
    p_addr_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |-> (addr_q <= last_q));
    p_step_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !at_last) |=> (addr_o == $past(addr_o) + 1'b1));
    p_finish_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && at_last) |=> (!run_o && $stable(addr_o)));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !tick_i && !stop_i) |=> (run_o && $stable(addr_o)));
    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && stop_i) |=> !run_o);
endmodule

// File: rtl/pin_slice.sv
module pin_slice #(
    parameter int DEPTH = 16,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          cap_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic          pin_i,
    input  logic          host_we_i,
    input  logic          host_sel_i,
    input  logic [AW-1:0] host_addr_i,
    input  logic          host_d_i,
    output logic          drv_en_o,
    output logic          drv_d_o,
    output logic          rd_o
);
    logic [DEPTH-1:0] dat_q;
    logic [DEPTH-1:0] dir_q;
    logic [DEPTH-1:0] cap_q;
    logic             host_ok;

    assign host_ok = host_we_i && !run_i && (host_addr_i <= AW'(DEPTH - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_q <= '0;
            dir_q <= '0;
        end else if (host_ok) begin
            if (host_sel_i) dir_q[host_addr_i] <= host_d_i;
            else            dat_q[host_addr_i] <= host_d_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cap_q <= '0;
        else if (cap_en_i) cap_q[addr_i] <= pin_i;
    end

    always_comb begin
        drv_en_o = run_i && dir_q[addr_i];
        drv_d_o  = drv_en_o && dat_q[addr_i];
        rd_o     = !run_i && cap_q[host_addr_i];
    end

    p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |=> ($stable(dat_q) && $stable(dir_q)));
    p_cap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en_i |=> $stable(cap_q));
    p_cap_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en_i |=> (cap_q[$past(addr_i)] == $past(pin_i)));
endmodule

// File: rtl/pat_pin_array.sv
module pat_pin_array
    import pin_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int DEPTH = 16,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_start,
    input  logic           run_stop,
    input  logic           step_tick,
    input  logic [AW-1:0]  last_step,
    input  logic           host_we,
    input  logic           host_sel,
    input  logic [AW-1:0]  host_addr,
    input  logic [NCH-1:0] host_wdata,
    output logic [NCH-1:0] host_rdata,
    input  logic [NCH-1:0] pin_rx,
    output logic [NCH-1:0] drv_data,
    output logic [NCH-1:0] drv_en,
    output logic           running,
    output logic [AW-1:0]  step_addr
);
    logic          run_w;
    logic          cap_en_w;
    logic [AW-1:0] addr_w;

    step_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (run_start),
        .stop_i   (run_stop),
        .tick_i   (step_tick),
        .last_i   (last_step),
        .run_o    (run_w),
        .cap_en_o (cap_en_w),
        .addr_o   (addr_w)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pin_slice #(.DEPTH(DEPTH), .AW(AW)) u_slice (
            .clk         (clk),
            .rst_n       (rst_n),
            .run_i       (run_w),
            .cap_en_i    (cap_en_w),
            .addr_i      (addr_w),
            .pin_i       (pin_rx[c]),
            .host_we_i   (host_we),
            .host_sel_i  (host_sel),
            .host_addr_i (host_addr),
            .host_d_i    (host_wdata[c]),
            .drv_en_o    (drv_en[c]),
            .drv_d_o     (drv_data[c]),
            .rd_o        (host_rdata[c])
        );
    end

    assign running   = run_w;
    assign step_addr = addr_w;

    p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_data & ~drv_en) == '0);
    p_idle_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (drv_en == '0));
    p_rd_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (host_rdata == '0));
endmodule

// File: tb/pat_pin_array_test.sv
module pat_pin_array_test;
    localparam int NCH   = 8;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           run_start = 1'b0, run_stop = 1'b0, step_tick = 1'b0;
    logic [AW-1:0]  last_step = '0;
    logic           host_we = 1'b0, host_sel = 1'b0;
    logic [AW-1:0]  host_addr = '0;
    logic [NCH-1:0] host_wdata = '0;
    logic [NCH-1:0] host_rdata, drv_data, drv_en, pin_rx;
    logic [NCH-1:0] ext = '0;
    logic           running;
    logic [AW-1:0]  step_addr;

    logic [NCH-1:0] m_dat [DEPTH];
    logic [NCH-1:0] m_dir [DEPTH];
    logic [NCH-1:0] m_cap [DEPTH];

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    assign pin_rx = (drv_en & drv_data) | (~drv_en & ext);

    pat_pin_array #(.NCH(NCH), .DEPTH(DEPTH), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .run_start(run_start), .run_stop(run_stop),
        .step_tick(step_tick), .last_step(last_step), .host_we(host_we),
        .host_sel(host_sel), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .pin_rx(pin_rx), .drv_data(drv_data),
        .drv_en(drv_en), .running(running), .step_addr(step_addr)
    );

    function automatic logic [NCH-1:0] exp_drv(input logic [NCH-1:0] d, input logic [NCH-1:0] r);
        return d & r;
    endfunction

    function automatic logic [NCH-1:0] exp_pin(input logic [NCH-1:0] d, input logic [NCH-1:0] r,
                                               input logic [NCH-1:0] e);
        return (r & d) | (~r & e);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input bit sel, input int a, input logic [NCH-1:0] d, input bit idle);
        host_we = 1'b1; host_sel = sel; host_addr = AW'(a); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        if (idle) begin
            if (sel) m_dir[a] = d;
            else     m_dat[a] = d;
        end
    endtask

    task automatic read_all();
        for (int a = 0; a < DEPTH; a++) begin
            host_addr = AW'(a);
            #1;
            chk(host_rdata === m_cap[a], "R9/R6 capture readback", 32'(host_rdata), 32'(m_cap[a]));
        end
    endtask

    task automatic do_run(input int last);
        last_step = AW'(last);
        run_start = 1'b1;
        @(negedge clk);
        run_start = 1'b0;
        last_step = ~AW'(last);  // R2: later change must be ignored
        chk(running === 1'b1, "R2 launch running", 32'(running), 1);
        for (int k = 0; k <= last; k++) begin
            chk(step_addr === AW'(k), "R3 step address", 32'(step_addr), 32'(k));
            chk(drv_en === m_dir[k], "R4 driver enable", 32'(drv_en), 32'(m_dir[k]));
            chk(drv_data === exp_drv(m_dat[k], m_dir[k]), "R5 driver data",
                32'(drv_data), 32'(exp_drv(m_dat[k], m_dir[k])));
            ext = NCH'($urandom);
            m_cap[k] = exp_pin(m_dat[k], m_dir[k], ext);
            if (k == 1) begin
                host_addr = AW'(k);
                #1;
                chk(host_rdata === '0, "R9 read while running", 32'(host_rdata), 0);
                host_we = 1'b1; host_sel = $urandom_range(0, 1);
                host_addr = AW'($urandom_range(0, DEPTH - 1));
                host_wdata = NCH'($urandom);  // R8: must be ignored
            end
            if (k == 2) run_start = 1'b1;     // R2: ignored while running
            step_tick = 1'b1;
            @(negedge clk);
            step_tick = 1'b0; host_we = 1'b0; run_start = 1'b0;
            if (k < last) begin
                int gap = $urandom_range(0, 2);
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    chk(step_addr === AW'(k + 1), "R3 hold without tick", 32'(step_addr), 32'(k + 1));
                end
            end
        end
        chk(running === 1'b0, "R3 finish at last step", 32'(running), 0);
        chk(step_addr === AW'(last), "R3 address holds at last", 32'(step_addr), 32'(last));
        chk(drv_en === '0, "R4 idle drivers off", 32'(drv_en), 0);
        read_all();
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int a = 0; a < DEPTH; a++) begin m_dat[a] = '0; m_dir[a] = '0; m_cap[a] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(running === 1'b0, "R1 reset idle", 32'(running), 0);
        chk(step_addr === '0, "R1 reset address", 32'(step_addr), 0);
        chk(drv_en === '0, "R1 reset enable", 32'(drv_en), 0);
        chk(drv_data === '0, "R1 reset data", 32'(drv_data), 0);
        read_all();

        for (int a = 0; a < DEPTH; a++) begin
            host_wr(1'b0, a, NCH'($urandom), 1'b1);
            host_wr(1'b1, a, NCH'($urandom), 1'b1);
        end
        host_wr(1'b1, 0, '1, 1'b1);   // all-output step
        host_wr(1'b1, 1, '0, 1'b1);   // all-input step
        host_wr(1'b0, 0, NCH'(8'hA5), 1'b1);

        do_run(DEPTH - 1);
        do_run(0);
        for (int r = 0; r < 4; r++) begin
            host_wr(1'b1, $urandom_range(0, DEPTH - 1), NCH'($urandom), 1'b1);
            host_wr(1'b0, $urandom_range(0, DEPTH - 1), NCH'($urandom), 1'b1);
            do_run($urandom_range(3, DEPTH - 1));
        end

        // R7: stop with a tick in the same cycle
        last_step = AW'(DEPTH - 1);
        run_start = 1'b1;
        @(negedge clk);
        run_start = 1'b0;
        for (int k = 0; k < 2; k++) begin
            ext = NCH'($urandom);
            m_cap[k] = exp_pin(m_dat[k], m_dir[k], ext);
            step_tick = 1'b1;
            @(negedge clk);
            step_tick = 1'b0;
        end
        ext = ~m_cap[2];
        step_tick = 1'b1; run_stop = 1'b1;
        @(negedge clk);
        step_tick = 1'b0; run_stop = 1'b0;
        chk(running === 1'b0, "R7 stop ends run", 32'(running), 0);
        chk(step_addr === AW'(2), "R7 no advance on stop", 32'(step_addr), 2);
        read_all();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule